// File: doc/BRIEF.md
# Bidirectional IO Pad Edge and Pipeline Path

This block carries one group of IO pad bits through its digital datapath in both directions. Fabric data headed for the pad can pass through an optional register stage. It is then launched by a flop clocked on the rising edge or on the falling edge of the pad clock. The launched word leaves the block toward an external delay line. The pad output is either the delayed copy returned by that line or the undelayed launched word.

On the way in, the block chooses between the raw pad value and its delayed copy. It captures the chosen value on the rising or the falling edge, then passes it either through an optional rising-edge register or around it to the fabric. The delay line sits after every transmit register and ahead of every receive register. Because of this, the transmit pad timing never depends on the register settings, while the receive register setting decides whether a falling-edge capture reaches the fabric in half a cycle or on the next rising edge.

The per-direction control bits come from configuration registers and are held steady by the user. Synthesis-time parameters set the data width and whether each pipeline register is built at all.

Top module: `io_pad_pipe`

## Requirements
- R1: An active-low `rst_n` clears every register at once, without waiting for a clock edge; while it is low, `tx_launch` and `rx_fab_q` read zero.
- R2: With `tx_cfg_neg`=0, `tx_launch` changes only at rising clock edges.
- R3: With `tx_cfg_neg`=1, `tx_launch` updates at the falling edge, half a cycle before the rising-edge setting would show the same word.
- R4: The transmit pipeline register is in use only when `tx_cfg_reg`=1 and `tx_cfg_skip`=0. Then a fabric word reaches `tx_launch` two rising edges after it is sampled in rising mode, and at the falling edge after the first rising edge in falling mode.
- R5: With `tx_cfg_reg`=0 or `tx_cfg_skip`=1, a fabric word reaches `tx_launch` at the first rising edge (rising mode) or at the first falling edge (falling mode).
- R6: `tx_pad` equals `tx_dly_d` when `tx_cfg_dly`=1 and `tx_launch` otherwise, for every pipeline setting.
- R7: The receive capture source is `rx_dly_d` when `rx_cfg_dly`=1 and `rx_pad` otherwise; the other input has no effect on `rx_fab_q`.
- R8: With `rx_cfg_neg`=0 and the receive register unused, `rx_fab_q` shows the source sampled at the previous rising edge.
- R9: With `rx_cfg_neg`=1 and the receive register unused, `rx_fab_q` shows the source right after the falling edge that captured it.
- R10: With the receive register in use (`rx_cfg_reg`=1, `rx_cfg_skip`=0), a rising capture reaches `rx_fab_q` one rising edge after capture, and a falling capture reaches it at the next rising edge.
- R11: `rx_cfg_reg`=0 and `rx_cfg_skip`=1 each leave the receive register unused, with the same timing as R8 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pad clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_cfg_neg | input | 1 | Launch transmit data on the falling edge |
| tx_cfg_dly | input | 1 | Drive the pad from the delayed transmit copy |
| tx_cfg_reg | input | 1 | Enable the transmit pipeline register |
| tx_cfg_skip | input | 1 | Route around the transmit pipeline register |
| rx_cfg_neg | input | 1 | Capture receive data on the falling edge |
| rx_cfg_dly | input | 1 | Capture from the delayed receive copy |
| rx_cfg_reg | input | 1 | Enable the receive pipeline register |
| rx_cfg_skip | input | 1 | Route around the receive pipeline register |
| tx_fab_d | input | W | Transmit word from the fabric |
| tx_launch | output | W | Launched word sent to the external delay line |
| tx_dly_d | input | W | Delayed transmit word returned by the delay line |
| tx_pad | output | W | Word driven to the pad |
| rx_pad | input | W | Undelayed receive word from the pad |
| rx_dly_d | input | W | Delayed receive word from the delay line |
| rx_fab_q | output | W | Receive word delivered to the fabric |

## Verification
If the transmit pipeline register were inserted when it should not be, or the wrong launch flop were selected, `tx_launch` would show a word one cycle late or half a cycle off within two edges of the fabric change. It would never show a wrong value without a timing shift. A receive capture on the wrong edge or a wrong source choice corrupts `rx_fab_q` by the next falling edge in falling mode and by the next rising edge otherwise. For this reason, outputs are sampled both after each rising edge and after each falling edge. A reset that only acts on a clock edge is exposed by reading the outputs a fraction of a nanosecond after `rst_n` falls between edges.

// File: rtl/io_pad_pipe_pkg.sv
package io_pad_pipe_pkg;

   // Control bits of one direction, as held in the configuration registers.
   typedef struct packed {
      logic neg_edge;   // launch or capture on the falling edge
      logic dly_en;     // take the delayed copy
      logic reg_en;     // pipeline register requested
      logic pipe_skip;  // route around the pipeline register
   } dir_cfg_t;

   // The pipeline register is only in the path when requested and not skipped.
   function automatic logic stage_used(dir_cfg_t c);
      return c.reg_en && !c.pipe_skip;
   endfunction

endpackage

// File: rtl/io_dly_sel.sv
module io_dly_sel #(
   parameter int W = 4
) (
   input  logic         use_dly,
   input  logic [W-1:0] direct_d,
   input  logic [W-1:0] delayed_d,
   output logic [W-1:0] y
);

   assign y = use_dly ? delayed_d : direct_d;

endmodule

// File: rtl/io_edge_reg.sv
module io_edge_reg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         neg_sel,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] q_rise;
   logic [W-1:0] q_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_rise <= '0;
      else        q_rise <= d;
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) q_fall <= '0;
      else        q_fall <= d;
   end

   assign q = neg_sel ? q_fall : q_rise;

endmodule

// File: rtl/io_pipe_stage.sv
module io_pipe_stage #(
   parameter int W       = 4,
   parameter bit PRESENT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (PRESENT) begin : g_reg
         logic [W-1:0] held;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) held <= '0;
            else        held <= d;
         end
         assign q = active ? held : d;
      end else begin : g_wire
         logic unused_ctl;
         assign unused_ctl = ^{clk, rst_n, active};
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/io_pad_pipe.sv
module io_pad_pipe #(
   parameter int W       = 4,
   parameter bit TX_PIPE = 1'b1,
   parameter bit RX_PIPE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tx_cfg_neg,
   input  logic         tx_cfg_dly,
   input  logic         tx_cfg_reg,
   input  logic         tx_cfg_skip,
   input  logic         rx_cfg_neg,
   input  logic         rx_cfg_dly,
   input  logic         rx_cfg_reg,
   input  logic         rx_cfg_skip,
   input  logic [W-1:0] tx_fab_d,
   output logic [W-1:0] tx_launch,
   input  logic [W-1:0] tx_dly_d,
   output logic [W-1:0] tx_pad,
   input  logic [W-1:0] rx_pad,
   input  logic [W-1:0] rx_dly_d,
   output logic [W-1:0] rx_fab_q
);
   import io_pad_pipe_pkg::*;

   generate
      if (W < 1) begin : g_bad_width
         $error("io_pad_pipe: W must be at least 1");
      end
   endgenerate

   dir_cfg_t tx_cfg;
   dir_cfg_t rx_cfg;
   assign tx_cfg = '{neg_edge: tx_cfg_neg, dly_en: tx_cfg_dly,
                     reg_en: tx_cfg_reg, pipe_skip: tx_cfg_skip};
   assign rx_cfg = '{neg_edge: rx_cfg_neg, dly_en: rx_cfg_dly,
                     reg_en: rx_cfg_reg, pipe_skip: rx_cfg_skip};

   // Transmit: pipeline, then edge launch, then delay choice at the pad.
   logic [W-1:0] tx_staged;

   io_pipe_stage #(.W(W), .PRESENT(TX_PIPE)) u_tx_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (stage_used(tx_cfg)),
      .d      (tx_fab_d),
      .q      (tx_staged)
   );

   io_edge_reg #(.W(W)) u_tx_launch (
      .clk     (clk),
      .rst_n   (rst_n),
      .neg_sel (tx_cfg.neg_edge),
      .d       (tx_staged),
      .q       (tx_launch)
   );

   io_dly_sel #(.W(W)) u_tx_sel (
      .use_dly   (tx_cfg.dly_en),
      .direct_d  (tx_launch),
      .delayed_d (tx_dly_d),
      .y         (tx_pad)
   );

   // Receive: delay choice, then edge capture, then pipeline to the fabric.
   logic [W-1:0] rx_src;
   logic [W-1:0] rx_cap;

   io_dly_sel #(.W(W)) u_rx_sel (
      .use_dly   (rx_cfg.dly_en),
      .direct_d  (rx_pad),
      .delayed_d (rx_dly_d),
      .y         (rx_src)
   );

   io_edge_reg #(.W(W)) u_rx_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .neg_sel (rx_cfg.neg_edge),
      .d       (rx_src),
      .q       (rx_cap)
   );

   io_pipe_stage #(.W(W), .PRESENT(RX_PIPE)) u_rx_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (stage_used(rx_cfg)),
      .d      (rx_cap),
      .q      (rx_fab_q)
   );

endmodule

// File: rtl/io_pad_pipe_chk.sv
module io_pad_pipe_chk #(
   parameter int W       = 4,
   parameter bit TX_PIPE = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tx_cfg_neg,
   input logic         tx_cfg_reg,
   input logic         tx_cfg_skip,
   input logic         rx_cfg_neg,
   input logic         rx_cfg_dly,
   input logic         rx_cfg_reg,
   input logic         rx_cfg_skip,
   input logic [W-1:0] tx_fab_d,
   input logic [W-1:0] tx_launch,
   input logic [W-1:0] rx_pad,
   input logic [W-1:0] rx_dly_d,
   input logic [W-1:0] rx_fab_q
);

   logic tx_byp;
   logic rx_byp;
   assign tx_byp = !(tx_cfg_reg && !tx_cfg_skip);
   assign rx_byp = !(rx_cfg_reg && !rx_cfg_skip);

   // R1: outputs held at zero throughout reset
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |-> (tx_launch == '0 && rx_fab_q == '0));

   // R5: rising launch with the register bypassed is one edge late
   a_r5_tx_direct: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !tx_cfg_neg && $past(!tx_cfg_neg && tx_byp))
      |-> tx_launch == $past(tx_fab_d));

   // R3: falling launch with the register bypassed, seen at falling edges
   a_r3_tx_fall: assert property (@(negedge clk) disable iff (!rst_n)
      ($past(rst_n) && tx_cfg_neg && $past(tx_cfg_neg && tx_byp))
      |-> tx_launch == $past(tx_fab_d));

   // R8 and R7: rising receive capture around the register
   a_r8_rx_rise_direct: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !rx_cfg_neg && rx_byp && $past(!rx_cfg_neg))
      |-> rx_fab_q == ($past(rx_cfg_dly) ? $past(rx_dly_d) : $past(rx_pad)));

   generate
      if (TX_PIPE) begin : g_tx_pipe_chk
         // R4: rising launch through the register is two edges late
         a_r4_tx_piped: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n, 2) && $past(rst_n) && !tx_cfg_neg &&
             $past(!tx_cfg_neg && !tx_byp))
            |-> tx_launch == $past(tx_fab_d, 2));
      end
   endgenerate

endmodule

bind io_pad_pipe io_pad_pipe_chk #(.W(W), .TX_PIPE(TX_PIPE)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_cfg_neg  (tx_cfg_neg),
   .tx_cfg_reg  (tx_cfg_reg),
   .tx_cfg_skip (tx_cfg_skip),
   .rx_cfg_neg  (rx_cfg_neg),
   .rx_cfg_dly  (rx_cfg_dly),
   .rx_cfg_reg  (rx_cfg_reg),
   .rx_cfg_skip (rx_cfg_skip),
   .tx_fab_d    (tx_fab_d),
   .tx_launch   (tx_launch),
   .rx_pad      (rx_pad),
   .rx_dly_d    (rx_dly_d),
   .rx_fab_q    (rx_fab_q)
);

// File: tb/sim_io_pad_pipe.sv
`timescale 1ns/100ps
module sim_io_pad_pipe;

   localparam int W     = 4;
   localparam int NCYC  = 8;
   localparam int NROW  = 8;

   // [15:8] {tx_neg,tx_dly,tx_reg,tx_skip,rx_neg,rx_dly,rx_reg,rx_skip}
   // [7:0]  {tx_early,tx_late,rx_early,rx_late} lag in cycles
   localparam logic [15:0] VEC [NROW] = '{
      {8'b0000_0000, 8'b01_01_01_01},
      {8'b0010_0010, 8'b10_10_10_10},
      {8'b1010_1010, 8'b10_01_01_01},
      {8'b1000_1000, 8'b01_00_01_00},
      {8'b0011_0011, 8'b01_01_01_01},
      {8'b1101_1101, 8'b01_00_01_00},
      {8'b0110_0110, 8'b10_10_10_10},
      {8'b1110_1110, 8'b10_01_01_01}
   };

   logic clk = 1'b0;
   logic rst_n;
   logic tx_cfg_neg, tx_cfg_dly, tx_cfg_reg, tx_cfg_skip;
   logic rx_cfg_neg, rx_cfg_dly, rx_cfg_reg, rx_cfg_skip;
   logic [W-1:0] tx_fab_d, tx_launch, tx_dly_d, tx_pad;
   logic [W-1:0] rx_pad, rx_dly_d, rx_fab_q;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [W-1:0] hist [NCYC];

   always #2 clk = ~clk;

   io_pad_pipe #(.W(W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .tx_cfg_neg(tx_cfg_neg), .tx_cfg_dly(tx_cfg_dly),
      .tx_cfg_reg(tx_cfg_reg), .tx_cfg_skip(tx_cfg_skip),
      .rx_cfg_neg(rx_cfg_neg), .rx_cfg_dly(rx_cfg_dly),
      .rx_cfg_reg(rx_cfg_reg), .rx_cfg_skip(rx_cfg_skip),
      .tx_fab_d(tx_fab_d), .tx_launch(tx_launch), .tx_dly_d(tx_dly_d),
      .tx_pad(tx_pad), .rx_pad(rx_pad), .rx_dly_d(rx_dly_d),
      .rx_fab_q(rx_fab_q)
   );

   task automatic chk(input string tag, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic drive(input logic [W-1:0] v);
      tx_fab_d = v;
      tx_dly_d = ~v;
      rx_pad   = rx_cfg_dly ? ~v : v;
      rx_dly_d = rx_cfg_dly ? v : ~v;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b1;
      {tx_cfg_neg, tx_cfg_dly, tx_cfg_reg, tx_cfg_skip} = 4'b0;
      {rx_cfg_neg, rx_cfg_dly, rx_cfg_reg, rx_cfg_skip} = 4'b0;
      tx_fab_d = '0; tx_dly_d = '0; rx_pad = '0; rx_dly_d = '0;
      #1 rst_n = 1'b0;
      drive(4'h6);
      repeat (2) @(posedge clk);
      #1;
      chk("R1 reset tx_launch", tx_launch, '0);
      chk("R1 reset rx_fab_q", rx_fab_q, '0);
      chk("R1 reset tx_pad", tx_pad, '0);
      rst_n = 1'b1;

      for (int r = 0; r < NROW; r++) begin
         logic [7:0] cfg;
         logic [1:0] tke, tkl, rke, rkl;
         string ttag, rtag;
         cfg = VEC[r][15:8];
         {tke, tkl, rke, rkl} = VEC[r][7:0];
         if (cfg[7]) ttag = cfg[5] && !cfg[4] ? "R3 R4" : "R3 R5";
         else        ttag = cfg[5] && !cfg[4] ? "R2 R4" : "R2 R5";
         if (cfg[1] && !cfg[0]) rtag = "R10";
         else if (cfg[1] || cfg[0]) rtag = "R11";
         else rtag = cfg[3] ? "R9" : "R8";
         if (cfg[2]) rtag = {"R7 ", rtag};
         for (int i = 0; i < NCYC; i++) begin
            logic [W-1:0] v;
            v = W'(i * 5 + r * 3 + 1);
            @(posedge clk);
            #1;
            if (i >= 3) begin
               chk({ttag, " early"}, tx_launch, hist[i - tke]);
               chk({"R6 ", ttag}, tx_pad,
                   tx_cfg_dly ? tx_dly_d : hist[i - tke]);
               chk({rtag, " early"}, rx_fab_q, hist[i - rke]);
            end
            if (i == 0) begin
               {tx_cfg_neg, tx_cfg_dly, tx_cfg_reg, tx_cfg_skip} = cfg[7:4];
               {rx_cfg_neg, rx_cfg_dly, rx_cfg_reg, rx_cfg_skip} = cfg[3:0];
            end
            hist[i] = v;
            drive(v);
            #2;
            if (i >= 3) begin
               chk({ttag, " late"}, tx_launch, hist[i - tkl]);
               chk({rtag, " late"}, rx_fab_q, hist[i - rkl]);
            end
         end
      end

      // R1: reset taking effect between clock edges
      {tx_cfg_neg, tx_cfg_dly, tx_cfg_reg, tx_cfg_skip} = 4'b1000;
      {rx_cfg_neg, rx_cfg_dly, rx_cfg_reg, rx_cfg_skip} = 4'b1000;
      @(posedge clk);
      #1 drive(4'hB);
      #2;
      chk("R9 before async reset", rx_fab_q, 4'hB);
      chk("R3 before async reset", tx_launch, 4'hB);
      rst_n = 1'b0;
      #0.5;
      chk("R1 async tx_launch", tx_launch, '0);
      chk("R1 async rx_fab_q", rx_fab_q, '0);
      @(posedge clk);
      #1;
      chk("R1 held tx_launch", tx_launch, '0);
      chk("R1 held rx_fab_q", rx_fab_q, '0);
      rst_n = 1'b1;

      done = 1'b1;
      finish_run();
   end

endmodule